// File: doc/BRIEF.md
# Vector Register Group Hazard Scoreboard

This block guards issue in an in-order vector sequencer. Each arriving instruction names a destination register and up to two source registers, together with a register-group multiplier code. An instruction can instead be flagged as a whole-register move, which carries its own register count. The block turns each operand into a set of architectural registers that covers the whole group. It then compares these sets against a small table of in-flight instructions and holds `stall_o` high until no live older entry conflicts. The checks cover read-after-write, write-after-read and write-after-write overlaps.

An instruction that does not stall is written into the lowest free table slot, and that slot index is reported. The execution side later pulses that slot's completion bit, which frees the entry. The freed entry stops counting against requests in the same cycle as the pulse. Every slot keeps its own read set. A writer therefore waits for every older reader of an overlapping register, including a long-latency reader that outlives younger ones.

A simplified ordering mode is selected by `drain_mode_i`. A small state machine has two states, `ST_RUN` and `ST_DRAIN`. In `ST_RUN`, a request whose multiplier code differs from the last issued one, while entries are still live, causes the transition `ST_RUN -> ST_DRAIN`. In `ST_DRAIN` every request stalls until the table is empty. The transition `ST_DRAIN -> ST_RUN` is then taken.

Top module: `vgrp_hazard_sb`

## Requirements
- R1: The group code c selects a group of 2^c registers (0->1, 1->2, 2->4, 3->8). An issued destination vd marks registers vd through vd+2^c-1 as pending writes. A later request that reads any of them stalls while that entry is live (read-after-write).
- R2: With `req_whole_i` high, the group size comes from `req_nreg_i` (same code) and not from `req_lmul_i`. The move writes the vd group and reads the vs2 group; vs1 is ignored.
- R3: A request whose write set overlaps the read set of any live entry stalls (write-after-read). The stall stays until every such entry has completed, whatever their completion order.
- R4: A request whose write set overlaps the write set of any live entry stalls (write-after-write).
- R5: With `req_masked_i` high, register v0 is added to the request's read set.
- R6: `err_o` is high when a valid request has an operand base that is not a multiple of its group size. Only the destination and the sources in use count. Such a request stalls and never issues.
- R7: When all slots are valid and none is completing, a valid request stalls.
- R8: A completion pulse on a slot removes that entry from hazard and fullness checks in the same cycle. The entry is invalid from the next cycle.
- R9: An issued request goes to the lowest-numbered slot that is either invalid or completing. `issue_slot_o` gives that index.
- R10: With `drain_mode_i` high, a request whose group code differs from the last issued code stalls while any entry is live (`ST_RUN -> ST_DRAIN`). In `ST_DRAIN` every request stalls until no entry is live. With `drain_mode_i` low, a code change alone does not stall.
- R11: After reset the table is empty, the state is `ST_RUN` and the last code is 0. A legal request issues into slot 0.
- R12: `stall_o`, `issue_o` and `err_o` are low when `req_valid_i` is low. `issue_o` equals `req_valid_i` and not `stall_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| drain_mode_i | input | 1 | Selects the simplified drain-on-code-change ordering |
| req_valid_i | input | 1 | An instruction is presented for issue |
| req_vd_i | input | 5 | Destination group base |
| req_vs1_i | input | 5 | First source group base |
| req_vs2_i | input | 5 | Second source group base |
| req_use_vs1_i | input | 1 | First source is read |
| req_use_vs2_i | input | 1 | Second source is read |
| req_masked_i | input | 1 | Operation is masked, reads v0 |
| req_lmul_i | input | 2 | Group multiplier code |
| req_whole_i | input | 1 | Whole-register move |
| req_nreg_i | input | 2 | Register count code for a whole-register move |
| done_i | input | 8 | Per-slot completion pulses |
| stall_o | output | 1 | Request must wait |
| issue_o | output | 1 | Request is accepted this cycle |
| issue_slot_o | output | 3 | Slot the accepted request occupies |
| err_o | output | 1 | Request has a misaligned group base |

## Verification
The hardest situation to reach is a writer held by two older readers of the same group that complete out of order. The younger, shorter reader retires first, and the stall must survive until the older one also finishes. A directed sequence builds this case. It issues a long reader, then a short reader of v8..v15, then presents a v8-group writer while completing the short reader first. Constrained-random traffic with a fixed seed adds overlapping groups of mixed sizes and random completion pulses. A bench model predicts every cycle's stall, issue slot and error flag, and the traffic runs in both ordering modes.

// File: rtl/vgrp_pkg.sv
package vgrp_pkg;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_DRAIN = 1'b1
    } sb_state_e;

    typedef logic [1:0] grp_code_t;

endpackage

// File: rtl/vgrp_mask_gen.sv
module vgrp_mask_gen
    import vgrp_pkg::*;
#(
    parameter int NREG = 32,
    localparam int REGW = $clog2(NREG)
) (
    input  logic [REGW-1:0] vd_i,
    input  logic [REGW-1:0] vs1_i,
    input  logic [REGW-1:0] vs2_i,
    input  logic            use_vs1_i,
    input  logic            use_vs2_i,
    input  logic            masked_i,
    input  grp_code_t       lmul_i,
    input  logic            whole_i,
    input  grp_code_t       nreg_i,
    output logic [NREG-1:0] rd_mask_o,
    output logic [NREG-1:0] wr_mask_o,
    output logic            err_o
);

    function automatic logic [NREG-1:0] span(input logic [REGW-1:0] base, input grp_code_t c);
        logic [NREG-1:0] m;
        for (int r = 0; r < NREG; r++) begin
            m[r] = (r >= int'(base)) && (r < int'(base) + (1 << c));
        end
        return m;
    endfunction

    function automatic logic misal(input logic [REGW-1:0] base, input grp_code_t c);
        return (int'(base) % (1 << c)) != 0;
    endfunction

    grp_code_t code;

    always_comb begin
        code      = whole_i ? nreg_i : lmul_i;
        wr_mask_o = span(vd_i, code);
        rd_mask_o = '0;
        if (whole_i) begin
            rd_mask_o = span(vs2_i, code);
        end else begin
            if (use_vs1_i) rd_mask_o = rd_mask_o | span(vs1_i, code);
            if (use_vs2_i) rd_mask_o = rd_mask_o | span(vs2_i, code);
        end
        if (masked_i) rd_mask_o[0] = 1'b1;
        if (whole_i) begin
            err_o = misal(vd_i, code) | misal(vs2_i, code);
        end else begin
            err_o = misal(vd_i, code) | (use_vs1_i & misal(vs1_i, code))
                  | (use_vs2_i & misal(vs2_i, code));
        end
    end

endmodule

// File: rtl/vgrp_slot_table.sv
module vgrp_slot_table #(
    parameter int NSLOT = 8,
    parameter int NREG  = 32,
    localparam int SLOTW = $clog2(NSLOT)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NREG-1:0]  req_rd_i,
    input  logic [NREG-1:0]  req_wr_i,
    input  logic             alloc_i,
    input  logic [NSLOT-1:0] done_i,
    output logic             hazard_o,
    output logic             full_o,
    output logic             any_live_o,
    output logic [SLOTW-1:0] free_slot_o
);

    logic [NSLOT-1:0] valid_q;
    logic [NREG-1:0]  rd_q [NSLOT];
    logic [NREG-1:0]  wr_q [NSLOT];
    logic [NSLOT-1:0] live;
    logic [NSLOT-1:0] free;

    assign live = valid_q & ~done_i;
    assign free = ~valid_q | done_i;

    always_comb begin
        hazard_o = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (live[i] && ((|(req_rd_i & wr_q[i])) || (|(req_wr_i & rd_q[i]))
                            || (|(req_wr_i & wr_q[i])))) begin
                hazard_o = 1'b1;
            end
        end
    end

    always_comb begin
        free_slot_o = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (free[i]) free_slot_o = SLOTW'(i);
        end
    end

    assign full_o     = ~|free;
    assign any_live_o = |live;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            valid_q <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                rd_q[i] <= '0;
                wr_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (alloc_i && free_slot_o == SLOTW'(i)) begin
                    valid_q[i] <= 1'b1;
                    rd_q[i]    <= req_rd_i;
                    wr_q[i]    <= req_wr_i;
                end else if (done_i[i]) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    end

    // R9: allocation only lands on a slot that is free or completing
    p_alloc_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alloc_i |-> (!valid_q[free_slot_o] || done_i[free_slot_o]));

    // R9: allocated slot is valid in the following cycle
    p_alloc_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alloc_i |=> valid_q[$past(free_slot_o)]);

    // R7: no allocation while every slot stays occupied
    p_full_no_alloc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alloc_i |-> !(&(valid_q & ~done_i)));

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot_chk
        // R8: a completion pulse frees its slot
        p_done_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (done_i[g] && !(alloc_i && free_slot_o == SLOTW'(g))) |=> !valid_q[g]);
    end

endmodule

// File: rtl/vgrp_hazard_sb.sv
module vgrp_hazard_sb
    import vgrp_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int NSLOT = 8,
    localparam int REGW  = $clog2(NREG),
    localparam int SLOTW = $clog2(NSLOT)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             drain_mode_i,
    input  logic             req_valid_i,
    input  logic [REGW-1:0]  req_vd_i,
    input  logic [REGW-1:0]  req_vs1_i,
    input  logic [REGW-1:0]  req_vs2_i,
    input  logic             req_use_vs1_i,
    input  logic             req_use_vs2_i,
    input  logic             req_masked_i,
    input  logic [1:0]       req_lmul_i,
    input  logic             req_whole_i,
    input  logic [1:0]       req_nreg_i,
    input  logic [NSLOT-1:0] done_i,
    output logic             stall_o,
    output logic             issue_o,
    output logic [SLOTW-1:0] issue_slot_o,
    output logic             err_o
);

    logic [NREG-1:0]  rd_mask;
    logic [NREG-1:0]  wr_mask;
    logic             grp_err;
    logic             hazard;
    logic             full;
    logic             any_live;
    logic [SLOTW-1:0] free_slot;
    sb_state_e        state_q;
    sb_state_e        state_d;
    grp_code_t        last_q;
    logic             code_chg;
    logic             drain_blk;

    vgrp_mask_gen #(.NREG(NREG)) u_mask (
        .vd_i      (req_vd_i),
        .vs1_i     (req_vs1_i),
        .vs2_i     (req_vs2_i),
        .use_vs1_i (req_use_vs1_i),
        .use_vs2_i (req_use_vs2_i),
        .masked_i  (req_masked_i),
        .lmul_i    (req_lmul_i),
        .whole_i   (req_whole_i),
        .nreg_i    (req_nreg_i),
        .rd_mask_o (rd_mask),
        .wr_mask_o (wr_mask),
        .err_o     (grp_err)
    );

    vgrp_slot_table #(.NSLOT(NSLOT), .NREG(NREG)) u_tab (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_rd_i    (rd_mask),
        .req_wr_i    (wr_mask),
        .alloc_i     (issue_o),
        .done_i      (done_i),
        .hazard_o    (hazard),
        .full_o      (full),
        .any_live_o  (any_live),
        .free_slot_o (free_slot)
    );

    assign code_chg = (req_lmul_i != last_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_RUN;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            if (issue_o) last_q <= req_lmul_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (req_valid_i && drain_mode_i && code_chg && any_live) state_d = ST_DRAIN;
            ST_DRAIN: if (!any_live) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:   drain_blk = drain_mode_i && code_chg && any_live;
            ST_DRAIN: drain_blk = any_live;
            default:  drain_blk = 1'b0;
        endcase
        stall_o      = req_valid_i && (grp_err || hazard || full || drain_blk);
        issue_o      = req_valid_i && !stall_o;
        err_o        = req_valid_i && grp_err;
        issue_slot_o = free_slot;
    end

    // R6: a misaligned request is never accepted
    p_err_no_issue_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> !issue_o);

    // R10: while draining with live entries nothing issues
    p_drain_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_DRAIN && any_live) |-> !issue_o);

    // R10: in drain mode a code change issues only into an empty table
    p_drain_chg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (issue_o && drain_mode_i && code_chg) |-> !any_live);

    // R12: idle request port gives quiet outputs
    p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |-> (!stall_o && !issue_o && !err_o));

endmodule

// File: tb/vgrp_hazard_sb_tb.sv
module vgrp_hazard_sb_tb_top;

    localparam time CLK_P = 8ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dm = 1'b0;
    logic       rv = 1'b0;
    logic [4:0] vd = '0, vs1 = '0, vs2 = '0;
    logic       u1 = 1'b0, u2 = 1'b0, msk = 1'b0, wh = 1'b0;
    logic [1:0] lm = '0, nr = '0;
    logic [7:0] done = '0;
    logic       stall, issue, err;
    logic [2:0] slot;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  m_v = '0;
    logic [31:0] m_rd [8];
    logic [31:0] m_wr [8];
    logic        m_drain = 1'b0;
    logic [1:0]  m_last = '0;
    logic        a_stall, a_issue, a_err;
    logic [2:0]  a_slot;

    always #(CLK_P/2) clk = ~clk;

    vgrp_hazard_sb dut_i (
        .clk_i(clk), .rst_ni(rst_n), .drain_mode_i(dm), .req_valid_i(rv),
        .req_vd_i(vd), .req_vs1_i(vs1), .req_vs2_i(vs2),
        .req_use_vs1_i(u1), .req_use_vs2_i(u2), .req_masked_i(msk),
        .req_lmul_i(lm), .req_whole_i(wh), .req_nreg_i(nr), .done_i(done),
        .stall_o(stall), .issue_o(issue), .issue_slot_o(slot), .err_o(err)
    );

    function automatic logic [31:0] gm(input logic [4:0] b, input logic [1:0] c);
        logic [31:0] m = '0;
        for (int r = 0; r < 32; r++) m[r] = (r >= int'(b)) && (r < int'(b) + (1 << c));
        return m;
    endfunction

    function automatic logic mis(input logic [4:0] b, input logic [1:0] c);
        return (int'(b) % (1 << c)) != 0;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic setreq(input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2,
                          input logic a1, input logic a2, input logic m,
                          input logic [1:0] l, input logic w, input logic [1:0] n);
        rv = 1'b1; vd = d; vs1 = s1; vs2 = s2; u1 = a1; u2 = a2; msk = m;
        lm = l; wh = w; nr = n;
    endtask

    // one cycle: model prediction vs ports, then model update
    task automatic step(input string tag);
        logic [1:0]  c;
        logic [31:0] wr, rd;
        logic        e, hz, full, dblk, st, is;
        logic [7:0]  live, free;
        logic [2:0]  fs;
        #2;
        c  = wh ? nr : lm;
        wr = gm(vd, c);
        if (wh) rd = gm(vs2, c);
        else rd = (u1 ? gm(vs1, c) : 32'h0) | (u2 ? gm(vs2, c) : 32'h0);
        if (msk) rd[0] = 1'b1;
        e = wh ? (mis(vd, c) | mis(vs2, c)) : (mis(vd, c) | (u1 & mis(vs1, c)) | (u2 & mis(vs2, c)));
        live = m_v & ~done;
        free = ~m_v | done;
        hz = 1'b0;
        for (int i = 0; i < 8; i++)
            if (live[i] && ((|(rd & m_wr[i])) || (|(wr & m_rd[i])) || (|(wr & m_wr[i])))) hz = 1'b1;
        fs = 3'd0;
        for (int i = 7; i >= 0; i--) if (free[i]) fs = 3'(i);
        full = (free == 8'h0);
        dblk = m_drain ? (|live) : (dm && (lm != m_last) && (|live));
        st = rv && (e || hz || full || dblk);
        is = rv && !st;
        a_stall = stall; a_issue = issue; a_err = err; a_slot = slot;
        chk({stall, issue, err} == {st, is, rv & e}, {tag, " flags"},
            int'({stall, issue, err}), int'({st, is, rv & e}));
        if (is) chk(slot == fs, {tag, " slot R9"}, int'(slot), int'(fs));
        if (m_drain) m_drain = |live;
        else m_drain = rv && dm && (lm != m_last) && (|live);
        m_v = m_v & ~done;
        if (is) begin
            m_v[fs] = 1'b1; m_rd[fs] = rd; m_wr[fs] = wr; m_last = lm;
        end
        @(negedge clk);
    endtask

    task automatic drain_all();
        rv = 1'b0; done = m_v;
        step("R8 clear");
        done = '0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog R12 actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) begin m_rd[i] = '0; m_wr[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 / R12: reset state and idle port
        step("R12 idle");
        chk(!a_stall && !a_issue && !a_err, "R12 idle quiet", int'({a_stall, a_issue}), 0);
        setreq(5'd1, 5'd2, 5'd3, 1, 1, 0, 2'd0, 0, 2'd0);
        step("R11 first");
        chk(a_issue && a_slot == 3'd0, "R11 first issue", int'(a_slot), 0);
        drain_all();

        // R1: group of eight written, read of v12 stalls
        setreq(5'd8, 5'd16, 5'd24, 1, 1, 0, 2'd3, 0, 2'd0);
        step("R1 writer");
        setreq(5'd4, 5'd12, 5'd16, 1, 0, 0, 2'd0, 0, 2'd0);
        step("R1 reader");
        chk(a_stall, "R1 read of v12 stalls", int'(a_stall), 1);
        done = 8'h01;
        step("R8 same cycle");
        chk(a_issue && a_slot == 3'd0, "R8 released same cycle", int'({a_issue, a_slot}), 8);
        done = '0;
        drain_all();

        // R2: whole-register move of eight at group code 0
        setreq(5'd8, 5'd0, 5'd16, 0, 0, 0, 2'd0, 1, 2'd3);
        step("R2 move");
        setreq(5'd4, 5'd12, 5'd0, 1, 0, 0, 2'd0, 0, 2'd0);
        step("R2 raw");
        chk(a_stall, "R2 read v12 after move stalls", int'(a_stall), 1);
        setreq(5'd20, 5'd1, 5'd0, 1, 0, 0, 2'd0, 0, 2'd0);
        step("R2 war");
        chk(a_stall, "R2 write v20 over move source stalls", int'(a_stall), 1);
        drain_all();

        // R3: two readers of v8..v15, younger finishes first
        setreq(5'd24, 5'd0, 5'd8, 0, 1, 0, 2'd3, 0, 2'd0);
        step("R3 long");
        setreq(5'd16, 5'd0, 5'd8, 0, 1, 0, 2'd3, 0, 2'd0);
        step("R3 short");
        setreq(5'd8, 5'd0, 5'd0, 0, 1, 0, 2'd3, 0, 2'd0);
        step("R3 writer");
        chk(a_stall, "R3 writer stalls", int'(a_stall), 1);
        done = 8'h02;
        step("R3 short done");
        chk(a_stall, "R3 still held by long reader", int'(a_stall), 1);
        done = 8'h00;
        step("R3 wait");
        chk(a_stall, "R3 still held", int'(a_stall), 1);
        done = 8'h01;
        step("R3 long done");
        chk(a_issue, "R3 released", int'(a_issue), 1);
        done = '0;
        drain_all();

        // R4: write-after-write
        setreq(5'd4, 5'd5, 5'd0, 1, 0, 0, 2'd0, 0, 2'd0);
        step("R4 first");
        setreq(5'd4, 5'd6, 5'd0, 1, 0, 0, 2'd0, 0, 2'd0);
        step("R4 second");
        chk(a_stall, "R4 waw stalls", int'(a_stall), 1);
        drain_all();

        // R5: masked operation reads v0
        setreq(5'd0, 5'd0, 5'd0, 0, 0, 0, 2'd0, 0, 2'd0);
        step("R5 v0 writer");
        setreq(5'd2, 5'd0, 5'd3, 0, 1, 1, 2'd0, 0, 2'd0);
        step("R5 masked");
        chk(a_stall, "R5 masked op stalls on v0", int'(a_stall), 1);
        setreq(5'd2, 5'd0, 5'd3, 0, 1, 0, 2'd0, 0, 2'd0);
        step("R5 unmasked");
        chk(a_issue, "R5 unmasked issues", int'(a_issue), 1);
        drain_all();

        // R6: misaligned bases
        setreq(5'd3, 5'd0, 5'd0, 0, 0, 0, 2'd1, 0, 2'd0);
        step("R6 vd");
        chk(a_err && a_stall && !a_issue, "R6 misaligned vd", int'({a_err, a_stall, a_issue}), 6);
        setreq(5'd4, 5'd0, 5'd6, 0, 0, 0, 2'd0, 1, 2'd2);
        step("R6 move");
        chk(a_err && !a_issue, "R6 misaligned move source", int'({a_err, a_issue}), 2);

        // R7 / R9: fill the table
        for (int i = 0; i < 8; i++) begin
            setreq(5'(8 + i), 5'd0, 5'd0, 0, 0, 0, 2'd0, 0, 2'd0);
            step("R9 fill");
            chk(a_slot == 3'(i), "R9 ascending slot", int'(a_slot), i);
        end
        setreq(5'd20, 5'd0, 5'd0, 0, 0, 0, 2'd0, 0, 2'd0);
        step("R7 full");
        chk(a_stall, "R7 full stalls", int'(a_stall), 1);
        done = 8'h20;
        step("R9 reuse");
        chk(a_issue && a_slot == 3'd5, "R9 reuse completing slot", int'(a_slot), 5);
        done = '0;
        drain_all();

        // R10: drain mode
        dm = 1'b1;
        setreq(5'd1, 5'd0, 5'd0, 0, 0, 0, 2'd0, 0, 2'd0);
        step("R10 base");
        setreq(5'd8, 5'd0, 5'd0, 0, 0, 0, 2'd2, 0, 2'd0);
        step("R10 change");
        chk(a_stall, "R10 code change stalls", int'(a_stall), 1);
        setreq(5'd2, 5'd0, 5'd0, 0, 0, 0, 2'd0, 0, 2'd0);
        step("R10 in drain");
        chk(a_stall, "R10 drain holds same code", int'(a_stall), 1);
        done = 8'h01;
        step("R10 empty");
        chk(a_issue, "R10 issue once empty", int'(a_issue), 1);
        done = '0;
        dm = 1'b0;
        setreq(5'd10, 5'd0, 5'd0, 0, 0, 0, 2'd1, 0, 2'd0);
        step("R10 off");
        chk(a_issue, "R10 no drain when mode off", int'(a_issue), 1);
        drain_all();

        // random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            logic [1:0] c;
            dm = (k >= 2000);
            rv = ($urandom % 4) != 0;
            wh = ($urandom % 8) == 0;
            lm = 2'($urandom % 4);
            nr = 2'($urandom % 4);
            c  = wh ? nr : lm;
            vd  = 5'($urandom % 32) & ~5'((1 << c) - 1);
            vs1 = 5'($urandom % 32) & ~5'((1 << c) - 1);
            vs2 = 5'($urandom % 32) & ~5'((1 << c) - 1);
            if (($urandom % 16) == 0) vd = 5'($urandom % 32);
            u1 = 1'($urandom); u2 = 1'($urandom); msk = ($urandom % 4) == 0;
            done = m_v & 8'($urandom) & 8'($urandom);
            step("R12 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule